// File: doc/BRIEF.md
# I2C Master Byte Controller with Arbitration

This block lets a processor run an I2C bus one byte at a time through three small registers: control, status and data. Software enables the block and raises the master bit to claim the bus. It writes a byte to send or reads the data register to fetch one. It waits for the interrupt that ends each byte, then drops the master bit to release the bus. Software does the sequencing. The block produces the line-level waveform: START, repeated START, STOP, eight data bits and the acknowledge bit, at a bit rate set by a fixed divider parameter.

The block drives the bus as open drain. Each of SCL and SDA has an enable output that pulls the line low, and each line is sampled back through a two-stage synchronizer. A bus monitor watches for START and STOP conditions from any master and keeps a busy flag. The block can also lose the bus to another master. If that happens mid-byte, it stops driving SDA, finishes clocking the byte, and then reports the loss and leaves master mode. If software tries to start while another master holds a line low, the attempt is refused and flagged. Addresses: 0 = control, 1 = status, 2 = data. Reads are combinational from `addr`.

Top module: `i2cb_ctrl`

## Requirements
- R1: After reset, control and status read 0x00, `irq` is low and neither `scl_oe` nor `sda_oe` is asserted.
- R2: A control write that moves the master bit (bit 5) from 0 to 1 with enable (bit 7) set, while both lines read high, produces a START (SDA falls while SCL is high). After the START the block holds SCL low, the busy flag (status bit 5) is set and arbitration-lost (status bit 4) stays clear.
- R3: In transmit mode (control bit 4 = 1), writing the data register while holding the bus shifts that byte out MSB first, one bit per SCL pulse.
- R4: At the end of the ninth SCL pulse of a byte, the interrupt flag (status bit 1) and the `irq` output go high.
- R5: A status write clears arbitration-lost and the interrupt flag wherever the written bit is 0, so writing 0x00 clears both.
- R6: After each transmitted byte, status bit 0 holds the sampled acknowledge level: 0 when the target pulled SDA low, 1 when it did not.
- R7: Writing the master bit to 0 while holding the bus produces a STOP (SDA rises while SCL is high). Both lines are then released and the busy flag clears.
- R8: A control write with repeated-start (bit 2) set while holding the bus produces a new START without a STOP in between. Busy stays set, and bit 2 reads back 0.
- R9: In receive mode (control bit 4 = 0), a read of the data register while holding the bus clocks in one byte, MSB first. That read returns the previous byte, and a later read returns the new one.
- R10: During the ninth bit of a received byte, the block pulls SDA low when no-ack (control bit 3) is 0 and leaves it high when bit 3 is 1.
- R11: If the block releases SDA for a 1 in a transmitted data bit but samples it low while SCL is high, it drives SDA no more for that byte. It still produces all nine SCL pulses. Then it releases SCL without a STOP, sets arbitration-lost and the interrupt flag, and clears the master bit.
- R12: A START request made while either line reads low is refused. No line is driven, the master bit reads 0, and arbitration-lost and the interrupt flag are set.
- R13: The busy flag sets on any START condition seen on the lines, including one made by another master, and clears on any STOP condition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effect only; data is combinational) |
| addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| irq | output | 1 | Interrupt flag |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The assertions assume the lines change only as a wired-AND of this block's enables and other devices on the bus. They also assume that other devices change SDA while SCL is low, except when they deliberately make a START or STOP. The bench resolves both lines from the enables, a target model and a second-master pull-down. The target changes SDA only on SCL falling edges. The second master pulls SDA either while SCL is held low mid-byte, to force a lost arbitration, or while the bus is idle, to make a foreign START, and it releases SDA only when SCL is high to make a STOP. Software writes are issued only when the protocol allows them: a byte command waits until the previous interrupt has been cleared.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;

  typedef enum logic [2:0] {E_IDLE, E_START, E_HOLD, E_BIT, E_STOP, E_RSTART} eng_t;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;

  localparam int C_EN  = 7;
  localparam int C_MS  = 5;
  localparam int C_TX  = 4;
  localparam int C_NAK = 3;
  localparam int C_RS  = 2;

  localparam int S_BUSY = 5;
  localparam int S_AL   = 4;
  localparam int S_IRQ  = 1;
  localparam int S_RXAK = 0;

  // index of the final quarter-bit phase of each running state
  function automatic logic [1:0] last_phase(eng_t s);
    case (s)
      E_START, E_STOP:  return 2'd2;
      E_BIT, E_RSTART:  return 2'd3;
      default:          return 2'd0;
    endcase
  endfunction

  // a data bit pulls SDA low only for a 0 and only while the bus is still ours
  function automatic logic pull_for_bit(logic bit_val, logic lost);
    return !bit_val && !lost;
  endfunction

endpackage

// File: rtl/i2cb_tick.sv
module i2cb_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/i2cb_busmon.sv
module i2cb_busmon (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic start_det,
  output logic stop_det,
  output logic busy
);
  logic [1:0] scl_sync, sda_sync;
  logic       scl_d, sda_d;

  assign scl_s     = scl_sync[1];
  assign sda_s     = sda_sync[1];
  assign start_det = scl_s && scl_d && sda_d && !sda_s;
  assign stop_det  = scl_s && scl_d && !sda_d && sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= 2'b11;
      sda_sync <= 2'b11;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
      busy     <= 1'b0;
    end else begin
      scl_sync <= {scl_sync[0], scl_i};
      sda_sync <= {sda_sync[0], sda_i};
      scl_d    <= scl_s;
      sda_d    <= sda_s;
      if (start_det)     busy <= 1'b1;
      else if (stop_det) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/i2cb_engine.sv
module i2cb_engine
  import i2cb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       tick,
  input  logic       sda_s,
  input  logic       cmd_start,
  input  logic       cmd_byte,
  input  logic       cmd_rstart,
  input  logic       want_bus,
  input  logic       tx_mode,
  input  logic       no_ack,
  input  logic [7:0] tx_data,
  output eng_t       st,
  output logic       run,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic       byte_done,
  output logic       arb_end,
  output logic       lost_now,
  output logic [7:0] rx_data,
  output logic       rx_ack
);
  eng_t       st_q;
  logic [1:0] ph;
  logic [3:0] bitn;
  logic [7:0] sh;
  logic       samp, lost, txm, nak;
  logic       at_last, ack_bit;

  assign st        = st_q;
  assign run       = (st_q == E_START) || (st_q == E_BIT) || (st_q == E_STOP) || (st_q == E_RSTART);
  assign at_last   = tick && (ph == last_phase(st_q));
  assign ack_bit   = (bitn == 4'd8);
  assign byte_done = (st_q == E_BIT) && at_last && ack_bit && !lost;
  assign arb_end   = (st_q == E_BIT) && at_last && ack_bit && lost;
  assign lost_now  = lost;
  assign rx_data   = sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= E_IDLE; ph <= 2'd0; bitn <= 4'd0; sh <= 8'h00;
      samp <= 1'b1; lost <= 1'b0; txm <= 1'b0; nak <= 1'b0; rx_ack <= 1'b0;
    end else if (!en) begin
      st_q <= E_IDLE; ph <= 2'd0; lost <= 1'b0;
    end else begin
      case (st_q)
        E_IDLE: if (cmd_start) begin st_q <= E_START; ph <= 2'd0; end
        E_HOLD: begin
          ph <= 2'd0;
          if (!want_bus)      st_q <= E_STOP;
          else if (cmd_rstart) st_q <= E_RSTART;
          else if (cmd_byte) begin
            st_q <= E_BIT; bitn <= 4'd0; sh <= tx_data;
            txm <= tx_mode; nak <= no_ack; lost <= 1'b0;
          end
        end
        default: if (tick) begin
          if (st_q == E_BIT && ph == 2'd2) begin
            samp <= sda_s;
            if (txm && !ack_bit && sh[7] && !sda_s) lost <= 1'b1;
          end
          if (ph == last_phase(st_q)) begin
            ph <= 2'd0;
            case (st_q)
              E_START, E_RSTART: st_q <= E_HOLD;
              E_STOP:            st_q <= E_IDLE;
              default: begin
                if (ack_bit) begin
                  if (txm) rx_ack <= samp;
                  st_q <= lost ? E_IDLE : E_HOLD;
                end else begin
                  sh   <= {sh[6:0], samp};
                  bitn <= bitn + 4'd1;
                end
              end
            endcase
          end else begin
            ph <= ph + 2'd1;
          end
        end
      endcase
    end
  end

  always_comb begin
    scl_oe = 1'b0;
    sda_oe = 1'b0;
    case (st_q)
      E_START:  begin sda_oe = (ph != 2'd0); scl_oe = (ph == 2'd2); end
      E_HOLD:   scl_oe = 1'b1;
      E_BIT: begin
        scl_oe = (ph == 2'd0) || (ph == 2'd3);
        if (!ack_bit) sda_oe = txm && pull_for_bit(sh[7], lost);
        else          sda_oe = !txm && !nak && !lost;
      end
      E_STOP:   begin scl_oe = (ph == 2'd0); sda_oe = (ph != 2'd2); end
      E_RSTART: begin scl_oe = (ph == 2'd0) || (ph == 2'd3); sda_oe = (ph >= 2'd2); end
      default:  ;
    endcase
  end
endmodule

// File: rtl/i2cb_ctrl.sv
module i2cb_ctrl
  import i2cb_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe
);
  logic en_q, ms_q, tx_q, nak_q, al_q, irq_q;
  logic scl_s, sda_s, start_det, stop_det, busy;
  logic tick, run, byte_done, arb_end, lost_now, rx_ack;
  logic [7:0] rx_data;
  eng_t st;

  logic ctrl_wr, stat_wr, data_wr, data_rd;
  logic ms_rise, lines_idle, cmd_start, start_inhibit, cmd_rstart, cmd_byte;

  assign ctrl_wr = wr_en && (addr == A_CTRL);
  assign stat_wr = wr_en && (addr == A_STAT);
  assign data_wr = wr_en && (addr == A_DATA);
  assign data_rd = rd_en && (addr == A_DATA);

  assign lines_idle    = scl_s && sda_s;
  assign ms_rise       = ctrl_wr && wdata[C_EN] && wdata[C_MS] && !ms_q && (st == E_IDLE);
  assign cmd_start     = ms_rise && lines_idle;
  assign start_inhibit = ms_rise && !lines_idle;
  assign cmd_rstart    = ctrl_wr && wdata[C_RS] && ms_q && (st == E_HOLD);
  assign cmd_byte      = (st == E_HOLD) && ms_q && ((data_wr && tx_q) || (data_rd && !tx_q));

  i2cb_tick #(.DIV(DIV)) u_tick (.clk(clk), .rst_n(rst_n), .run(run), .tick(tick));

  i2cb_busmon u_mon (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .start_det(start_det), .stop_det(stop_det), .busy(busy)
  );

  i2cb_engine u_eng (
    .clk(clk), .rst_n(rst_n), .en(en_q), .tick(tick), .sda_s(sda_s),
    .cmd_start(cmd_start), .cmd_byte(cmd_byte), .cmd_rstart(cmd_rstart),
    .want_bus(ms_q), .tx_mode(tx_q), .no_ack(nak_q), .tx_data(wdata),
    .st(st), .run(run), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .byte_done(byte_done), .arb_end(arb_end), .lost_now(lost_now),
    .rx_data(rx_data), .rx_ack(rx_ack)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; ms_q <= 1'b0; tx_q <= 1'b0; nak_q <= 1'b0;
      al_q <= 1'b0; irq_q <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        en_q  <= wdata[C_EN];
        ms_q  <= wdata[C_MS] && wdata[C_EN] && !start_inhibit;
        tx_q  <= wdata[C_TX];
        nak_q <= wdata[C_NAK];
      end
      if (stat_wr) begin
        al_q  <= al_q && wdata[S_AL];
        irq_q <= irq_q && wdata[S_IRQ];
      end
      if (byte_done) irq_q <= 1'b1;
      if (arb_end || start_inhibit) begin
        al_q  <= 1'b1;
        irq_q <= 1'b1;
        ms_q  <= 1'b0;
      end
    end
  end

  assign irq = irq_q;

  always_comb begin
    case (addr)
      A_CTRL:  rdata = {en_q, 1'b0, ms_q, tx_q, nak_q, 3'b000};
      A_STAT:  rdata = {2'b00, busy, al_q, 2'b00, irq_q, rx_ack};
      A_DATA:  rdata = rx_data;
      default: rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/i2cb_chk.sv
module i2cb_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_oe,
  input logic sda_oe,
  input logic lost_now,
  input logic byte_done,
  input logic arb_end,
  input logic start_inhibit,
  input logic irq_q,
  input logic al_q,
  input logic ms_q,
  input logic start_det,
  input logic stop_det,
  input logic busy
);
  a_r11_sda_quiet_after_loss: assert property (@(posedge clk) disable iff (!rst_n)
    lost_now |-> !sda_oe);

  a_r11_loss_reported: assert property (@(posedge clk) disable iff (!rst_n)
    arb_end |=> (al_q && irq_q && !ms_q));

  a_r4_irq_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> irq_q);

  a_r12_refused_start_flags: assert property (@(posedge clk) disable iff (!rst_n)
    start_inhibit |=> (al_q && irq_q && !ms_q));

  a_r12_refused_start_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    start_inhibit |=> (!scl_oe && !sda_oe));

  a_r13_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> busy);

  a_r13_idle_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !busy);
endmodule

bind i2cb_ctrl i2cb_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .lost_now(lost_now), .byte_done(byte_done), .arb_end(arb_end),
  .start_inhibit(start_inhibit), .irq_q(irq_q), .al_q(al_q), .ms_q(ms_q),
  .start_det(start_det), .stop_det(stop_det), .busy(busy)
);

// File: tb/sim_i2cb_ctrl.sv
`timescale 1ns/1ps
module sim_i2cb_ctrl;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic irq, scl_oe, sda_oe;
  logic scl_line, sda_line;
  logic slv_low = 1'b0, ext_low = 1'b0;

  int total = 0, bad = 0;
  bit done = 1'b0;

  // bus and target model state
  int   p = 0;
  bit   first = 1'b0;
  int   mode = 0, next_mode = 0;   // 0 silent, 1 ack writes, 2 send read data
  logic [7:0] cap = 8'h00, rd_byte = 8'h5A;
  bit   ack_seen = 1'b0;
  int   start_cnt = 0, stop_cnt = 0, scl_falls = 0;
  bit   win = 1'b0, oe_seen = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  assign scl_line = ~scl_oe;
  assign sda_line = ~(sda_oe | slv_low | ext_low);

  i2cb_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  always @(negedge sda_line) if (scl_line === 1'b1) begin
    start_cnt++; p = 0; first = 1'b1; mode = next_mode; slv_low = 1'b0;
  end
  always @(posedge sda_line) if (scl_line === 1'b1) begin
    stop_cnt++; slv_low = 1'b0;
  end
  always @(posedge scl_line) begin
    if (p < 8) cap = {cap[6:0], sda_line};
    if (mode == 2 && p == 8) begin
      ack_seen = !sda_line;
      if (sda_line) next_mode = 0;
      else rd_byte = ~rd_byte;
    end
  end
  always @(negedge scl_line) begin
    scl_falls++;
    if (first) first = 1'b0;
    else p = p + 1;
    if (p == 9) begin p = 0; mode = next_mode; end
    case (mode)
      1: slv_low = (p == 8);
      2: slv_low = (p < 8) ? !rd_byte[7-p] : 1'b0;
      default: slv_low = 1'b0;
    endcase
  end
  always @(posedge clk) if (win && sda_oe) oe_seen = 1'b1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_irq(input string req);
    int k;
    k = 0;
    while (irq !== 1'b1 && k < 4000) begin @(negedge clk); k++; end
    if (irq !== 1'b1) chk(req, irq, 1);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    reg_rd(2'd0, d); chk("R1 ctrl", d, 8'h00);
    reg_rd(2'd1, d); chk("R1 status", d, 8'h00);
    chk("R1 irq", irq, 0);
    chk("R1 lines", {scl_oe, sda_oe}, 2'b00);
  endtask

  task automatic t_write;
    logic [7:0] d;
    int s0;
    next_mode = 1;
    s0 = start_cnt;
    reg_wr(2'd0, 8'h90);
    reg_wr(2'd0, 8'hB0);
    idle(40);
    chk("R2 start seen", start_cnt, s0 + 1);
    reg_rd(2'd1, d); chk("R2 busy, no loss", d, 8'h20);
    chk("R2 scl held low", scl_line, 0);
    next_mode = 0;                       // first byte acked, second not
    reg_wr(2'd2, 8'hA6);
    wait_irq("R4 irq first byte");
    chk("R3 bits out", cap, 8'hA6);
    chk("R4 irq pin", irq, 1);
    reg_rd(2'd1, d); chk("R6 ack low, R4 flag", d, 8'h22);
    reg_wr(2'd1, 8'h00);
    reg_rd(2'd1, d); chk("R5 cleared", d, 8'h20);
    reg_wr(2'd2, 8'h3C);
    wait_irq("R4 irq second byte");
    chk("R3 bits out 2", cap, 8'h3C);
    reg_rd(2'd1, d); chk("R6 no ack", d, 8'h23);
    reg_wr(2'd1, 8'h00);
    s0 = stop_cnt;
    reg_wr(2'd0, 8'h90);
    idle(40);
    chk("R7 stop seen", stop_cnt, s0 + 1);
    reg_rd(2'd1, d); chk("R7 busy clear", d[5], 0);
    chk("R7 lines high", {scl_line, sda_line}, 2'b11);
  endtask

  task automatic t_read;
    logic [7:0] d;
    int s0;
    next_mode = 1;
    reg_wr(2'd0, 8'hB0);
    idle(40);
    reg_wr(2'd2, 8'h10);
    wait_irq("R4 irq reg byte");
    reg_wr(2'd1, 8'h00);
    s0 = start_cnt;
    reg_wr(2'd0, 8'hB4);
    idle(40);
    chk("R8 restart seen", start_cnt, s0 + 1);
    reg_rd(2'd1, d); chk("R8 busy kept", d[5], 1);
    reg_rd(2'd0, d); chk("R8 bit self-clears", d, 8'hB0);
    next_mode = 2; rd_byte = 8'h5A;
    reg_wr(2'd2, 8'hA1);
    wait_irq("R4 irq addr byte");
    reg_rd(2'd1, d); chk("R6 addr acked", d[0], 0);
    reg_wr(2'd1, 8'h00);
    reg_wr(2'd0, 8'hA0);
    reg_rd(2'd2, d);                     // starts first receive
    wait_irq("R9 irq rx 1");
    reg_wr(2'd1, 8'h00);
    chk("R10 master acks", ack_seen, 1);
    reg_wr(2'd0, 8'hA8);
    reg_rd(2'd2, d);                     // returns byte 1, starts byte 2
    chk("R9 first byte", d, 8'h5A);
    wait_irq("R9 irq rx 2");
    reg_wr(2'd1, 8'h00);
    chk("R10 master no-acks", ack_seen, 0);
    reg_wr(2'd0, 8'h80);
    idle(40);
    reg_rd(2'd2, d); chk("R9 second byte", d, 8'hA5);
    reg_rd(2'd1, d); chk("R7 busy clear after read", d[5], 0);
  endtask

  task automatic t_arb;
    logic [7:0] d;
    int f0, s0;
    next_mode = 0;
    reg_wr(2'd0, 8'hB0);
    idle(40);
    f0 = scl_falls; s0 = stop_cnt; oe_seen = 1'b0;
    reg_wr(2'd2, 8'h80);
    ext_low = 1'b1; win = 1'b1;          // other master drives a 0 while SCL is low
    wait_irq("R11 irq on loss");
    win = 1'b0;
    chk("R11 nine clocks", scl_falls - f0, 9);
    chk("R11 sda never driven", oe_seen, 0);
    reg_rd(2'd1, d); chk("R11 status", d & 8'h12, 8'h12);
    reg_rd(2'd0, d); chk("R11 master cleared", d, 8'h90);
    chk("R11 scl released", scl_oe, 0);
    chk("R11 no stop", stop_cnt, s0);
    ext_low = 1'b0;
    idle(10);
    reg_rd(2'd1, d); chk("R13 busy cleared by foreign stop", d[5], 0);
    reg_wr(2'd1, 8'h00);
    reg_rd(2'd1, d); chk("R5 both flags cleared", d & 8'h12, 8'h00);
  endtask

  task automatic t_inhibit;
    logic [7:0] d;
    ext_low = 1'b1;
    idle(10);
    reg_rd(2'd1, d); chk("R13 busy from foreign start", d[5], 1);
    reg_wr(2'd0, 8'hB0);
    idle(20);
    reg_rd(2'd0, d); chk("R12 master refused", d, 8'h90);
    reg_rd(2'd1, d); chk("R12 flags", d & 8'h32, 8'h32);
    chk("R12 lines untouched", {scl_oe, sda_oe}, 2'b00);
    ext_low = 1'b0;
    idle(10);
    reg_rd(2'd1, d); chk("R13 busy clear", d[5], 0);
    reg_wr(2'd1, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(3);
    t_reset;
    t_write;
    t_read;
    t_arb;
    t_inhibit;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule